// File: doc/BRIEF.md
# Clock Loss Detector with Gray-Coded Crossing

This block checks that a fast monitored clock keeps running, using a slower, independent reference clock as its time base. In the monitored domain, a free-running step counter advances on every rising edge. Its value is held in Gray code, so only one bit changes per step. The reference domain takes this value through a synchronizer chain and compares each new sample with the one taken on the previous reference edge. If a sample has not moved, the monitored clock made no edge in that interval. A miss counter then steps, and a lost-clock flag is raised.

Equality is tested directly on the Gray codes. A sample caught while the counter is changing can only read as the old code or the new code, never as some unrelated value. A healthy but unaligned monitored clock therefore cannot produce a false miss. The miss counter accumulates over the whole run and saturates rather than wrapping. Right after reset, a short warm-up window suppresses comparisons while the synchronizer pipeline fills.

Top module: `clock_loss_monitor`

## Requirements
- R1: While `rst_n` is low, `miss_count` reads 0 and `clk_lost` reads 0; both are cleared asynchronously, with no reference edge needed.
- R2: While `mon_clk` runs at 1.25 times the `ref_clk` frequency or faster, `miss_count` stays 0 and `clk_lost` stays 0 across thousands of reference cycles.
- R3: The value that crosses into the reference domain is Gray coded. Exactly one bit changes on each monitored edge, including the wrap from the last code back to the first.
- R4: On each reference edge where the synchronized sample equals the previous one, `miss_count` rises by exactly one and `clk_lost` is 1, both in that same reference cycle. `clk_lost` is 0 in every cycle where `miss_count` did not step (below saturation).
- R5: When `mon_clk` stops for N reference cycles and then resumes, the final `miss_count` increase lies within N-2 and N+2. While the stall is under way, the count stays within 2 of the number of reference edges that saw no monitored edge.
- R6: `clk_lost` returns to 0 on the first reference cycle whose sample differs from the previous one, and `miss_count` holds its value from then on. It is never cleared except by reset.
- R7: `miss_count` saturates at 2^CNT_W-1 (255 with the default width of 8) and never wraps or decreases.
- R8: During the first WARM_CYC (default 4) reference cycles after the synchronized reset release, no miss is counted, even when `mon_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mon_clk | input | 1 | Monitored clock, expected to be faster than `ref_clk` |
| ref_clk | input | 1 | Independent reference clock that drives the detection logic |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized separately in each domain |
| miss_count | output | CNT_W | Saturating count of reference cycles in which the monitored clock made no edge |
| clk_lost | output | 1 | High in each reference cycle in which a miss is detected |

## Verification
The hardest situations to reach from the ports are the start and the end of a stall. There, the miss count legitimately lags or catches up by up to the synchronizer depth. The bench gates the monitored clock only at reference falling edges, with the two clock phases chosen so that no edges ever coincide. It keeps a behavioural count of reference edges that saw no monitored edge, and compares the design with it every cycle within a two-cycle band. It also drives the counter into saturation with a long stall. Finally, it resets the block with the monitored clock stopped, to expose the warm-up window.

// File: rtl/clm_pkg.sv
package clm_pkg;

  // Reflected binary code of a plain binary value
  function automatic logic [31:0] to_gray32(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/clm_reset_sync.sv
module clm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/clm_gray_counter.sv
module clm_gray_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] gray_o
);
  import clm_pkg::*;

  logic [WIDTH-1:0] bin_q, bin_d;
  logic [WIDTH-1:0] gray_q, gray_d;
  logic [31:0]      gray_wide;

  always_comb begin
    bin_d     = bin_q + 1'b1;
    gray_wide = to_gray32(32'(bin_d));
    gray_d    = gray_wide[WIDTH-1:0];
  end

  // Both registers step on the same edge; the Gray register feeds the
  // crossing directly, so no combinational path reaches the far domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;

endmodule

// File: rtl/clm_sync_chain.sv
module clm_sync_chain #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_i;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clm_stall_tracker.sv
module clm_stall_tracker #(
  parameter int WIDTH    = 4,
  parameter int CNT_W    = 8,
  parameter int WARM_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sample_i,
  output logic [CNT_W-1:0] miss_count_o,
  output logic             lost_o
);

  localparam int WARM_W = $clog2(WARM_CYC + 1);
  localparam logic [WARM_W-1:0] WARM_END = WARM_W'(WARM_CYC);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

  logic [WIDTH-1:0]  prev_q;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [CNT_W-1:0]  miss_q, miss_d;
  logic              lost_q, lost_d;
  logic              primed, unchanged, hit, warm_en, miss_en;

  always_comb begin
    primed    = (warm_q == WARM_END);
    unchanged = (sample_i == prev_q);
    hit       = primed && unchanged;
    warm_en   = !primed;
    miss_en   = hit && (miss_q != CNT_MAX);
    warm_d    = warm_q + 1'b1;
    miss_d    = miss_q + 1'b1;
    lost_d    = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
      miss_q <= '0;
      lost_q <= 1'b0;
    end else begin
      prev_q <= sample_i;
      lost_q <= lost_d;
      if (warm_en) warm_q <= warm_d;
      if (miss_en) miss_q <= miss_d;
    end
  end

  assign miss_count_o = miss_q;
  assign lost_o       = lost_q;

endmodule

// File: rtl/clock_loss_monitor.sv
module clock_loss_monitor #(
  parameter int GRAY_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int WARM_CYC    = 4
) (
  input  logic             mon_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] miss_count,
  output logic             clk_lost
);

  logic              mon_rst_n;
  logic              ref_rst_n;
  logic [GRAY_W-1:0] mon_gray;
  logic [GRAY_W-1:0] ref_sample;

  clm_reset_sync #(.STAGES(SYNC_STAGES)) u_mon_rst (
    .clk(mon_clk), .arst_n(rst_n), .srst_n(mon_rst_n)
  );

  clm_reset_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
  );

  clm_gray_counter #(.WIDTH(GRAY_W)) u_step (
    .clk(mon_clk), .rst_n(mon_rst_n), .gray_o(mon_gray)
  );

  clm_sync_chain #(.WIDTH(GRAY_W), .STAGES(SYNC_STAGES)) u_xing (
    .clk(ref_clk), .rst_n(ref_rst_n), .d_i(mon_gray), .q_o(ref_sample)
  );

  clm_stall_tracker #(.WIDTH(GRAY_W), .CNT_W(CNT_W), .WARM_CYC(WARM_CYC)) u_track (
    .clk(ref_clk), .rst_n(ref_rst_n), .sample_i(ref_sample),
    .miss_count_o(miss_count), .lost_o(clk_lost)
  );

endmodule

// File: rtl/clm_checker.sv
module clm_checker #(
  parameter int GRAY_W = 4,
  parameter int CNT_W  = 8
) (
  input logic              mon_clk,
  input logic              ref_clk,
  input logic              mon_rst_n,
  input logic              ref_rst_n,
  input logic [GRAY_W-1:0] mon_gray,
  input logic [CNT_W-1:0]  miss_count,
  input logic              clk_lost
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R3
  gray_one_bit_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    mon_rst_n |=> ($countones(mon_gray ^ $past(mon_gray)) == 1));

  // R4
  lost_steps_count_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (clk_lost && $past(miss_count) != CNT_MAX) |-> (miss_count == $past(miss_count) + 1'b1));

  // R6
  quiet_holds_count_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !clk_lost |-> $stable(miss_count));

  // R7
  no_wrap_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_rst_n |=> (miss_count >= $past(miss_count)));

endmodule

bind clock_loss_monitor clm_checker #(.GRAY_W(GRAY_W), .CNT_W(CNT_W)) u_chk (
  .mon_clk(mon_clk), .ref_clk(ref_clk), .mon_rst_n(mon_rst_n),
  .ref_rst_n(ref_rst_n), .mon_gray(mon_gray),
  .miss_count(miss_count), .clk_lost(clk_lost)
);

// File: tb/clock_loss_monitor_tb.sv
module clock_loss_monitor_tb;

  localparam int CNT_W   = 8;
  localparam int CNT_MAX = 255;

  logic ref_clk = 1'b0;
  logic mon_clk = 1'b0;
  logic mon_run = 1'b1;
  logic rst_n   = 1'b0;
  logic [CNT_W-1:0] miss_count;
  logic clk_lost;

  int checks = 0;
  int errors = 0;
  int ref_cycles = 0;
  bit done = 0;

  // Behavioural model: reference edges that saw no monitored edge
  int mon_edges = 0;
  int last_edges = 0;
  int model_stall = 0;

  // 50 MHz reference clock, rising edges at 10, 30, 50, ...
  always #10 ref_clk = ~ref_clk;

  // Monitored clock, period 16 ns, rising edges at 11 + 16k; gated by mon_run
  initial begin
    #3;
    forever begin
      #8 mon_clk = mon_run ? ~mon_clk : 1'b0;
    end
  end

  always @(posedge mon_clk) mon_edges++;

  always @(posedge ref_clk) begin
    ref_cycles++;
    if (mon_edges == last_edges) model_stall++;
    last_edges = mon_edges;
  end

  clock_loss_monitor u_dut (
    .mon_clk(mon_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .miss_count(miss_count), .clk_lost(clk_lost)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge ref_clk);
  endtask

  // Per-cycle tracking during the first stall (R4, R5)
  bit track = 0;
  int base_model = 0;
  int base_count = 0;
  int prev_seen = 0;
  always @(negedge ref_clk) begin
    if (track) begin
      automatic int m = model_stall - base_model;
      automatic int a = int'(miss_count) - base_count;
      check((a >= m - 2) && (a <= m + 2), "R5 stall tracking", a, m);
      check(clk_lost == (int'(miss_count) != prev_seen), "R4 flag with step",
            int'(clk_lost), int'(int'(miss_count) != prev_seen));
    end
    prev_seen = int'(miss_count);
  end

  // Watchdog
  initial begin
    wait (ref_cycles > 150000 || done);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", ref_cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (3) begin
      tick();
      check(miss_count == 0, "R1 count in reset", int'(miss_count), 0);
      check(clk_lost == 1'b0, "R1 flag in reset", int'(clk_lost), 0);
    end
    rst_n = 1'b1;
    repeat (12) tick();

    // R2: healthy clocks for thousands of cycles
    for (int i = 0; i < 5000; i++) begin
      tick();
      check(miss_count == 0, "R2 no miss healthy", int'(miss_count), 0);
      check(clk_lost == 1'b0, "R2 no flag healthy", int'(clk_lost), 0);
    end

    // R4/R5/R6: stall for 40 reference cycles
    base_model = model_stall;
    base_count = int'(miss_count);
    track = 1;
    mon_run = 1'b0;
    repeat (40) tick();
    mon_run = 1'b1;
    repeat (8) tick();
    track = 0;
    check((int'(miss_count) >= 38) && (int'(miss_count) <= 42), "R5 stall length",
          int'(miss_count), 40);
    check(clk_lost == 1'b0, "R6 flag clears after resume", int'(clk_lost), 0);
    begin
      automatic int held = int'(miss_count);
      repeat (20) tick();
      check(int'(miss_count) == held, "R6 count held after resume", int'(miss_count), held);
    end

    // R7: long stall drives the counter into saturation
    mon_run = 1'b0;
    repeat (300) tick();
    check(int'(miss_count) == CNT_MAX, "R7 saturated", int'(miss_count), CNT_MAX);
    check(clk_lost == 1'b1, "R4 flag during stall", int'(clk_lost), 1);
    repeat (5) tick();
    check(int'(miss_count) == CNT_MAX, "R7 no wrap", int'(miss_count), CNT_MAX);
    mon_run = 1'b1;
    repeat (8) tick();
    check(clk_lost == 1'b0, "R6 flag clears after saturation", int'(clk_lost), 0);
    check(int'(miss_count) == CNT_MAX, "R7 held at max", int'(miss_count), CNT_MAX);

    // R1: asynchronous clear between edges, with the monitored clock stopped
    mon_run = 1'b0;
    #3 rst_n = 1'b0;
    #1;
    check(miss_count == 0, "R1 async clear count", int'(miss_count), 0);
    check(clk_lost == 1'b0, "R1 async clear flag", int'(clk_lost), 0);
    repeat (3) tick();
    rst_n = 1'b1;

    // R8: warm-up suppresses misses even with no monitored clock
    repeat (4) begin
      tick();
      check(miss_count == 0, "R8 warm-up count", int'(miss_count), 0);
      check(clk_lost == 1'b0, "R8 warm-up flag", int'(clk_lost), 0);
    end
    repeat (30) tick();
    check(int'(miss_count) > 20, "R4 misses after warm-up", int'(miss_count), 26);
    check(clk_lost == 1'b1, "R4 flag while stopped", int'(clk_lost), 1);
    mon_run = 1'b1;
    repeat (10) tick();
    check(clk_lost == 1'b0, "R6 flag clears on restart", int'(clk_lost), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule